// File: doc/BRIEF.md
# Coalescing Store Buffer

The block sits between a processor core's store path and a backing cache. Each store carries an address of one 8-byte word, 64 bits of data and eight byte enables. The buffer sorts stores by the aligned 32-byte block they fall in. A store to a block that the buffer already holds is folded into that block's entry. A store to any other block claims a free entry. Each entry keeps the block number, 32 bytes of data and a 32-bit mask that records which bytes have been written.

Entries leave through a drain port in the order in which they were claimed, oldest first. The drain port presents the whole block, and the downstream cache takes it with a valid/ready handshake. The core is held off only when no entry can take its store. A barrier request stops new stores until everything already buffered has drained, and then gives a one-cycle completion pulse.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid`=0, `st_ready`=1, `bar_done`=0.
- R2: `st_addr` is a word address of 8-byte words. The block number is `st_addr[AW-1:2]` and the slot within the block is `st_addr[1:0]`. Store byte b (`st_data[8b+7:8b]`) lands at block byte slot*8+b. Block byte n appears at `dr_data[8n+7:8n]`, and mask bit n of `dr_mask` marks it written.
- R3: A store to a block that is already held merges into that entry. Only its enabled bytes are overwritten and have their mask bits set. All other bytes and mask bits of the entry are unchanged, and no new entry is used.
- R4: A store to a block that is not held claims a new entry while fewer than six entries are occupied. Its mask holds only the bytes that store enabled.
- R5: With all six entries occupied, `st_ready` is 0 for a store whose block is not held. It stays 0 until a drain handshake frees an entry. A store whose block is held is still accepted when the buffer is full.
- R6: Entries drain in the order they were claimed. `dr_valid` is 1 whenever an entry is held. `dr_blk` stays unchanged while `dr_valid`=1 and `dr_ready`=0.
- R7: An entry is freed at the clock edge where `dr_valid` and `dr_ready` are both 1, and the next entry is presented in the following cycle.
- R8: A store to the oldest entry's block merges into that entry if `dr_ready`=0 in that cycle. If `dr_ready`=1 in that cycle, the store goes into a fresh entry instead, which drains separately afterwards.
- R9: A `bar_req` pulse makes `st_ready` 0 from the next cycle until the barrier completes. `bar_done` is a one-cycle pulse that goes high one cycle after the last entry is freed. If the buffer is empty when the request is taken, `bar_done` goes high one cycle after the request edge. `bar_req` has no effect while a barrier is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW (29) | 8-byte word address of the store |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| dr_valid | output | 1 | Oldest entry is presented for draining |
| dr_ready | input | 1 | Backing cache takes the presented entry |
| dr_blk | output | AW-2 (27) | Block number of the presented entry |
| dr_data | output | 256 | Block data of the presented entry |
| dr_mask | output | 32 | Written-byte mask of the presented entry |
| bar_req | input | 1 | Barrier request pulse |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
Corrupted merge logic shows up as wrong bytes or mask bits in the very next drain of that block. The bench therefore sweeps every byte-enable pattern in every slot, then compares whole blocks and masks at the drain. A wrong occupancy count appears within one cycle, either as `st_ready` held low with room to spare or high when the buffer is full, or later as a drain whose order or block number is wrong. A lost or early barrier shows within a cycle of the last drain through the exact position of the `bar_done` pulse.

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf #(
  parameter int ENTRIES   = 6,
  parameter int BLK_BYTES = 32,
  parameter int ST_BYTES  = 8,
  parameter int AW        = 29
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       st_valid,
  output logic                       st_ready,
  input  logic [AW-1:0]              st_addr,
  input  logic [ST_BYTES*8-1:0]      st_data,
  input  logic [ST_BYTES-1:0]        st_be,
  output logic                       dr_valid,
  input  logic                       dr_ready,
  output logic [AW-$clog2(BLK_BYTES/ST_BYTES)-1:0] dr_blk,
  output logic [BLK_BYTES*8-1:0]     dr_data,
  output logic [BLK_BYTES-1:0]       dr_mask,
  input  logic                       bar_req,
  output logic                       bar_done
);
  localparam int SLOT_W = $clog2(BLK_BYTES / ST_BYTES);
  localparam int TAG_W  = AW - SLOT_W;
  localparam int DW     = BLK_BYTES * 8;
  localparam int CNT_W  = $clog2(ENTRIES + 1);
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [TAG_W-1:0]     tag_q  [ENTRIES];
  logic [DW-1:0]        data_q [ENTRIES];
  logic [BLK_BYTES-1:0] mask_q [ENTRIES];
  logic [TAG_W-1:0]     tag_n  [ENTRIES];
  logic [DW-1:0]        data_n [ENTRIES];
  logic [BLK_BYTES-1:0] mask_n [ENTRIES];
  logic [CNT_W-1:0]     cnt;
  logic                 bar_pend;

  logic [TAG_W-1:0]  st_tag;
  logic [SLOT_W-1:0] st_slot;
  logic              hit, deq, st_fire;
  logic [IDX_W-1:0]  hit_idx, tgt;

  assign st_tag   = st_addr[AW-1:SLOT_W];
  assign st_slot  = st_addr[SLOT_W-1:0];
  assign dr_valid = (cnt != '0);
  assign dr_blk   = tag_q[0];
  assign dr_data  = data_q[0];
  assign dr_mask  = mask_q[0];
  assign deq      = dr_valid && dr_ready;
  assign st_ready = !bar_pend && (hit || cnt < CNT_W'(ENTRIES));
  assign st_fire  = st_valid && st_ready;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (CNT_W'(k) < cnt && tag_q[k] == st_tag && !(k == 0 && dr_ready)) begin
        hit = 1'b1;
        hit_idx = IDX_W'(k);
      end
  end

  assign tgt = hit ? hit_idx - IDX_W'(deq) : IDX_W'(cnt - CNT_W'(deq));

  always_comb begin
    for (int k = 0; k < ENTRIES; k++) begin
      if (deq && k < ENTRIES - 1) begin
        tag_n[k]  = tag_q[k+1];
        data_n[k] = data_q[k+1];
        mask_n[k] = mask_q[k+1];
      end else if (deq) begin
        tag_n[k]  = '0;
        data_n[k] = '0;
        mask_n[k] = '0;
      end else begin
        tag_n[k]  = tag_q[k];
        data_n[k] = data_q[k];
        mask_n[k] = mask_q[k];
      end
      if (st_fire && tgt == IDX_W'(k)) begin
        if (!hit) begin
          tag_n[k]  = st_tag;
          mask_n[k] = '0;
        end
        for (int b = 0; b < ST_BYTES; b++)
          if (st_be[b]) begin
            data_n[k][(int'(st_slot) * ST_BYTES + b) * 8 +: 8] = st_data[b*8 +: 8];
            mask_n[k][int'(st_slot) * ST_BYTES + b] = 1'b1;
          end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int k = 0; k < ENTRIES; k++) begin
        tag_q[k]  <= '0;
        data_q[k] <= '0;
        mask_q[k] <= '0;
      end
    end else begin
      cnt <= cnt - CNT_W'(deq) + CNT_W'(st_fire && !hit);
      for (int k = 0; k < ENTRIES; k++) begin
        tag_q[k]  <= tag_n[k];
        data_q[k] <= data_n[k];
        mask_q[k] <= mask_n[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_pend <= 1'b0;
      bar_done <= 1'b0;
    end else begin
      bar_done <= 1'b0;
      if (bar_pend && cnt == '0) begin
        bar_pend <= 1'b0;
        bar_done <= 1'b1;
      end else if (bar_req) begin
        bar_pend <= 1'b1;
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(ENTRIES));
  a_r5_full_block: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(ENTRIES) && !hit) |-> !st_ready);
  a_r6_hold_head: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_blk)));
  a_r9_bar_block: assert property (@(posedge clk) disable iff (rst)
    bar_pend |-> !st_ready);
  a_r9_done_empty: assert property (@(posedge clk) disable iff (rst)
    bar_done |-> !dr_valid);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    bar_done |=> !bar_done);
endmodule

// File: tb/store_coalesce_buf_tb.sv
module store_coalesce_buf_tb;
  localparam int AW = 29;
  logic clk = 0, rst = 1;
  logic st_valid = 0, dr_ready = 0, bar_req = 0;
  logic st_ready, dr_valid, bar_done;
  logic [AW-1:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0] st_be = '0;
  logic [AW-3:0] dr_blk;
  logic [255:0] dr_data;
  logic [31:0] dr_mask;
  int checks = 0, failures = 0;

  logic [AW-3:0] m_tag [8];
  logic [255:0] m_data [8];
  logic [31:0] m_mask [8];
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  store_coalesce_buf u_dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_blk(dr_blk),
    .dr_data(dr_data), .dr_mask(dr_mask), .bar_req(bar_req), .bar_done(bar_done));

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_store(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    int idx;
    idx = -1;
    for (int k = 0; k < m_cnt; k++) if (m_tag[k] == a[AW-1:2]) idx = k;
    if (idx < 0) begin
      idx = m_cnt; m_cnt++;
      m_tag[idx] = a[AW-1:2]; m_mask[idx] = '0; m_data[idx] = '0;
    end
    for (int b = 0; b < 8; b++)
      if (be[b]) begin
        m_data[idx][(int'(a[1:0]) * 8 + b) * 8 +: 8] = d[b*8 +: 8];
        m_mask[idx][int'(a[1:0]) * 8 + b] = 1'b1;
      end
  endtask

  task automatic m_pop();
    for (int k = 0; k < 7; k++) begin
      m_tag[k] = m_tag[k+1]; m_data[k] = m_data[k+1]; m_mask[k] = m_mask[k+1];
    end
    m_cnt--;
  endtask

  task automatic st(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    m_store(a, d, be);
    #1 st_valid = 0;
  endtask

  task automatic drain(input string req);
    @(negedge clk); #1;
    chk(dr_valid == 1, req, 256'(dr_valid), 256'd1);
    chk(dr_blk == m_tag[0], req, 256'(dr_blk), 256'(m_tag[0]));
    chk(dr_data == m_data[0], req, dr_data, m_data[0]);
    chk(dr_mask == m_mask[0], req, 256'(dr_mask), 256'(m_mask[0]));
    dr_ready = 1;
    @(posedge clk);
    m_pop();
    #1 dr_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    chk(dr_valid == 0, "R1 dr_valid", 256'(dr_valid), 256'd0);
    chk(st_ready == 1, "R1 st_ready", 256'(st_ready), 256'd1);
    chk(bar_done == 0, "R1 bar_done", 256'(bar_done), 256'd0);

    // R2 R3: every enable pattern in every slot merged into one block
    for (int s = 0; s < 4; s++)
      for (int be = 1; be < 256; be++) begin
        logic [63:0] d;
        for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'((s * 37 + be * 5 + b * 11) & 255);
        st({27'd50, 2'(s)}, d, 8'(be));
      end
    @(negedge clk); #1;
    chk(m_cnt == 1 && dr_valid == 1, "R3 single entry", 256'(m_cnt), 256'd1);
    drain("R3 merged block");

    // R2 R4: sparse enables per slot, each slot its own block
    for (int s = 0; s < 4; s++)
      st({27'(300 + s), 2'(s)}, 64'h0123_4567_89ab_cdef ^ 64'(s), 8'(8'h81 >> s));
    for (int s = 0; s < 4; s++) drain("R4 per-slot block");

    // R5 R6 R7: fill six distinct blocks, refusal, merge when full, ordered drain
    for (int k = 0; k < 6; k++) st({27'(900 - k), 2'(k & 3)}, 64'(k * 64'h1111), 8'hff);
    @(negedge clk);
    st_valid = 1; st_addr = {27'd77, 2'd0}; st_be = 8'hff; #1;
    chk(st_ready == 0, "R5 full refuse", 256'(st_ready), 256'd0);
    @(negedge clk); #1;
    chk(st_ready == 0, "R5 stays refused", 256'(st_ready), 256'd0);
    st_valid = 0;
    st({27'd898, 2'd3}, 64'hdead_beef_0000_0001, 8'h3c);
    for (int k = 0; k < 6; k++) begin
      drain("R6 order");
      @(negedge clk); #1;
      chk(st_ready == 1, "R7 room after free", 256'(st_ready), 256'd1);
    end
    chk(dr_valid == 0, "R7 empty after drains", 256'(dr_valid), 256'd0);

    // R8: merge into head only while dr_ready low
    st({27'd5, 2'd0}, 64'h1111_2222_3333_4444, 8'h0f);
    st({27'd5, 2'd1}, 64'h5555_6666_7777_8888, 8'hf0);
    @(negedge clk);
    dr_ready = 1; st_valid = 1; st_addr = {27'd5, 2'd2}; st_data = 64'h9999_aaaa_bbbb_cccc; st_be = 8'hff;
    #1;
    chk(st_ready == 1, "R8 ready at head drain", 256'(st_ready), 256'd1);
    chk(dr_data == m_data[0], "R8 head excludes new store", dr_data, m_data[0]);
    chk(dr_mask == 32'h0000_f00f, "R8 head mask", 256'(dr_mask), 256'h0000_f00f);
    @(posedge clk);
    m_pop();
    m_store({27'd5, 2'd2}, 64'h9999_aaaa_bbbb_cccc, 8'hff);
    #1 dr_ready = 0; st_valid = 0;
    @(negedge clk); #1;
    chk(dr_mask == 32'h00ff_0000, "R8 fresh entry mask", 256'(dr_mask), 256'h00ff_0000);
    drain("R8 fresh entry");

    // R9: barrier with three entries
    for (int k = 0; k < 3; k++) st({27'(40 + k), 2'd1}, 64'(k + 7), 8'h0f);
    @(negedge clk); bar_req = 1;
    @(posedge clk); #1 bar_req = 0;
    @(negedge clk); #1;
    chk(st_ready == 0, "R9 stores held", 256'(st_ready), 256'd0);
    drain("R9 drain");
    drain("R9 drain");
    @(negedge clk); bar_req = 1;
    drain("R9 drain last");
    bar_req = 0;
    @(negedge clk); #1;
    chk(bar_done == 0, "R9 not yet done", 256'(bar_done), 256'd0);
    @(posedge clk); #1;
    chk(bar_done == 1, "R9 done pulse", 256'(bar_done), 256'd1);
    chk(st_ready == 1, "R9 stores resume", 256'(st_ready), 256'd1);
    @(posedge clk); #1;
    chk(bar_done == 0, "R9 pulse one cycle", 256'(bar_done), 256'd0);

    // R9: barrier on empty buffer
    @(negedge clk); bar_req = 1;
    @(posedge clk); #1 bar_req = 0;
    chk(bar_done == 0 && st_ready == 0, "R9 empty pending", 256'({bar_done, st_ready}), 256'd0);
    @(posedge clk); #1;
    chk(bar_done == 1, "R9 empty done", 256'(bar_done), 256'd1);
    @(posedge clk); #1;
    chk(bar_done == 0 && st_ready == 1, "R9 empty after", 256'({bar_done, st_ready}), 256'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule